// File: doc/BRIEF.md
# External Interrupt Controller Register Bank

This block collects up to 64 external interrupt lines (the default; the count is a parameter) and turns them into a single interrupt request for a parent controller. Each line has its own configuration bits:
- a mask bit;
- a sensitivity bit that selects edge or level;
- a polarity bit;
- a software trigger bit;
- a domain-enable bit that gates the line completely.

Configuration is held in 32-bit words, one bit per line. Line n uses word n/32, bit n%32. Every configuration field can be read at one address. Mask, sensitivity, polarity and software trigger also have write-1-to-set and write-1-to-clear aliases, so software can change single lines without a read-modify-write.

Each input line passes through a two-flop synchroniser, and edges are found on the synchronised value. An edge that qualifies is held in a latch until software writes 1 to the acknowledge alias for that line. In level mode the status bit follows the active level and is not latched. The status word shows every pending line whether or not it is masked. The request output is raised when any pending line is unmasked.

The bus is a single word-addressed port. It takes one write or one read per cycle, and read data returns one cycle after the read strobe.

Top module: `eic_top`

## Requirements
- R1: After reset every line is masked (mask word reads all ones), edge sensitive (sens 0), polarity 0, soft 0 and domain-disabled. The status word reads 0 and `irqOut` is 0.
- R2: Word address = byte offset / 4. The bank byte offsets are: status 0x000, ack 0x040, mask 0x080, mask-set 0x0C0, mask-clear 0x100, sens 0x140, sens-set 0x180, sens-clear 0x1C0, soft 0x200, soft-set 0x240, soft-clear 0x280, pol 0x300, pol-set 0x340, pol-clear 0x380, domain-enable 0x400. Line n is at word (n/32) of its bank, bit n%32. Alias banks, and words at or beyond the number of implemented words, read as 0. `busRdData` is updated on the clock edge that samples `busRe`.
- R3: In the mask, sens, soft and pol set aliases, a written 1 sets the bit. In the clear aliases, a written 1 clears the bit. A written 0 leaves the bit unchanged in both kinds of alias.
- R4: The domain-enable word is written directly. A line whose domain bit is 0 reports status 0 and does not latch edges.
- R5: With sens 0, a rising edge (pol 1) or a falling edge (pol 0) of the synchronised input latches the line's status bit. Edges of the other direction are ignored.
- R6: With sens 1, the status bit follows the synchronised input: high is active when pol is 1, low is active when pol is 0. The status bit drops when the level goes inactive.
- R7: Writing 1 to an ack bit clears that line's latched edge. Writing 0 has no effect. A new qualifying edge in the same cycle keeps the latch set.
- R8: A soft bit that is set makes the line's status pending (domain permitting) until the soft bit is cleared through soft-clear.
- R9: `irqOut` is 1 exactly when some status bit is 1 and its mask bit is 0. Status bits stay readable while the line is masked.
- R10: An input change driven before clock edge k reaches the status word after edge k+1. A read sampled at edge k or k+1 still returns the old value; a read sampled at edge k+2 sees the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWe | input | 1 | Write strobe |
| busRe | input | 1 | Read strobe |
| busAddr | input | 9 | Word address (byte offset / 4) |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, registered |
| pinIn | input | NUM_PINS | Asynchronous external interrupt lines |
| irqOut | output | 1 | Aggregated request to the parent controller |

## Verification
Some properties are checked on every cycle:
- at most one alias strobe is decoded per access;
- a set or clear alias leaves every written bit in its new state on the next cycle;
- an acknowledged bit is empty afterwards unless a new edge arrived;
- a disabled domain never gains a latched edge;
- a set soft bit always shows in status;
- a fully masked bank never raises the request.

Other behaviour only the bench scenarios can show, because it needs input histories:
- the two-cycle synchroniser delay;
- edge direction per polarity;
- level-follow versus latch behaviour;
- the read-data latency;
- the placement of line 63 in the second word.

These are measured against a behavioural model that is compared on every clock, including a long random mix of writes, reads and line toggles.

// File: rtl/eic_pkg.sv
package eic_pkg;

  localparam int REG_BITS   = 32;
  localparam int ADDR_W     = 9;
  localparam int WORD_IDX_W = 4;
  localparam int BANK_W     = 5;

  // Bank codes = busAddr[8:4] (byte offset >> 6)
  localparam logic [BANK_W-1:0] BANK_STATUS   = 5'd0;
  localparam logic [BANK_W-1:0] BANK_ACK      = 5'd1;
  localparam logic [BANK_W-1:0] BANK_MASK     = 5'd2;
  localparam logic [BANK_W-1:0] BANK_MASK_SET = 5'd3;
  localparam logic [BANK_W-1:0] BANK_MASK_CLR = 5'd4;
  localparam logic [BANK_W-1:0] BANK_SENS     = 5'd5;
  localparam logic [BANK_W-1:0] BANK_SENS_SET = 5'd6;
  localparam logic [BANK_W-1:0] BANK_SENS_CLR = 5'd7;
  localparam logic [BANK_W-1:0] BANK_SOFT     = 5'd8;
  localparam logic [BANK_W-1:0] BANK_SOFT_SET = 5'd9;
  localparam logic [BANK_W-1:0] BANK_SOFT_CLR = 5'd10;
  localparam logic [BANK_W-1:0] BANK_POL      = 5'd12;
  localparam logic [BANK_W-1:0] BANK_POL_SET  = 5'd13;
  localparam logic [BANK_W-1:0] BANK_POL_CLR  = 5'd14;
  localparam logic [BANK_W-1:0] BANK_DOM      = 5'd16;

  typedef struct packed {
    logic                  maskSet;
    logic                  maskClr;
    logic                  sensSet;
    logic                  sensClr;
    logic                  softSet;
    logic                  softClr;
    logic                  polSet;
    logic                  polClr;
    logic                  domWr;
    logic                  ackWr;
    logic                  rdEn;
    logic                  rdHit;
    logic [BANK_W-1:0]     rdBank;
    logic [WORD_IDX_W-1:0] word;
  } eic_strobe_t;

endpackage

// File: rtl/eic_ctrl.sv
module eic_ctrl
  import eic_pkg::*;
#(
  parameter int WORDS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [ADDR_W-1:0] busAddr,
  output eic_strobe_t       strobe
);

  logic [BANK_W-1:0]     bankSel;
  logic [WORD_IDX_W-1:0] wordSel;
  logic                  inRange;
  logic                  wrOk;

  assign bankSel = busAddr[ADDR_W-1:WORD_IDX_W];
  assign wordSel = busAddr[WORD_IDX_W-1:0];
  assign inRange = (int'(wordSel) < WORDS);
  assign wrOk    = busWe & inRange;

  always_comb begin
    strobe        = '0;
    strobe.word   = wordSel;
    strobe.rdEn   = busRe;
    strobe.rdHit  = busRe & inRange;
    strobe.rdBank = bankSel;
    case (bankSel)
      BANK_ACK:      strobe.ackWr   = wrOk;
      BANK_MASK_SET: strobe.maskSet = wrOk;
      BANK_MASK_CLR: strobe.maskClr = wrOk;
      BANK_SENS_SET: strobe.sensSet = wrOk;
      BANK_SENS_CLR: strobe.sensClr = wrOk;
      BANK_SOFT_SET: strobe.softSet = wrOk;
      BANK_SOFT_CLR: strobe.softClr = wrOk;
      BANK_POL_SET:  strobe.polSet  = wrOk;
      BANK_POL_CLR:  strobe.polClr  = wrOk;
      BANK_DOM:      strobe.domWr   = wrOk;
      default: ;
    endcase
  end

  // R2
  one_alias_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.maskSet, strobe.maskClr, strobe.sensSet, strobe.sensClr,
              strobe.softSet, strobe.softClr, strobe.polSet, strobe.polClr,
              strobe.domWr, strobe.ackWr}));

endmodule

// File: rtl/eic_sync.sv
module eic_sync #(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] rawIn,
  output logic [WIDTH-1:0] lvlNow,
  output logic [WIDTH-1:0] lvlPrev
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_line
    logic stageA;
    logic stageB;
    logic stageC;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stageA <= 1'b0;
        stageB <= 1'b0;
        stageC <= 1'b0;
      end else begin
        stageA <= rawIn[i];
        stageB <= stageA;
        stageC <= stageB;
      end
    end
    assign lvlNow[i]  = stageB;
    assign lvlPrev[i] = stageC;
  end

endmodule

// File: rtl/eic_datapath.sv
module eic_datapath
  import eic_pkg::*;
#(
  parameter int NUM_PINS = 64,
  parameter int WORDS    = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  eic_strobe_t               strobe,
  input  logic [REG_BITS-1:0]       busWrData,
  input  logic [WORDS*REG_BITS-1:0] lvlNow,
  input  logic [WORDS*REG_BITS-1:0] lvlPrev,
  output logic [REG_BITS-1:0]       busRdData,
  output logic                      irqOut
);

  localparam int PADW = WORDS * REG_BITS;

  function automatic logic [PADW-1:0] validBits();
    logic [PADW-1:0] v;
    for (int i = 0; i < PADW; i++) v[i] = (i < NUM_PINS);
    return v;
  endfunction

  localparam logic [PADW-1:0] PIN_VALID = validBits();

  logic [WORDS-1:0]    wordHit;
  logic [PADW-1:0]     wordSpan;
  logic [PADW-1:0]     wrSpread;
  logic [PADW-1:0]     wrBits;
  logic [PADW-1:0]     maskR, sensR, softR, polR, domR, edgeLat;
  logic [PADW-1:0]     activeLvl, edgeQual, edgeHit, ackBits, statusVec;
  logic [PADW-1:0]     rdVec;
  logic [REG_BITS-1:0] rdWord;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    assign wordHit[w]                        = (int'(strobe.word) == w);
    assign wordSpan[w*REG_BITS +: REG_BITS]  = {REG_BITS{wordHit[w]}};
    assign wrSpread[w*REG_BITS +: REG_BITS]  = wordHit[w] ? busWrData : '0;
  end

  assign wrBits = wrSpread & PIN_VALID;

  // configuration words
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskR <= PIN_VALID;
      sensR <= '0;
      softR <= '0;
      polR  <= '0;
      domR  <= '0;
    end else begin
      if (strobe.maskSet) maskR <= maskR | wrBits;
      if (strobe.maskClr) maskR <= maskR & ~wrBits;
      if (strobe.sensSet) sensR <= sensR | wrBits;
      if (strobe.sensClr) sensR <= sensR & ~wrBits;
      if (strobe.softSet) softR <= softR | wrBits;
      if (strobe.softClr) softR <= softR & ~wrBits;
      if (strobe.polSet)  polR  <= polR | wrBits;
      if (strobe.polClr)  polR  <= polR & ~wrBits;
      if (strobe.domWr)   domR  <= (domR & ~wordSpan) | wrBits;
    end
  end

  // detection
  assign activeLvl = (polR & lvlNow) | (~polR & ~lvlNow);
  assign edgeQual  = (polR & lvlNow & ~lvlPrev) | (~polR & ~lvlNow & lvlPrev);
  assign edgeHit   = domR & ~sensR & edgeQual & PIN_VALID;
  assign ackBits   = strobe.ackWr ? wrBits : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) edgeLat <= '0;
    else       edgeLat <= (edgeLat & ~ackBits) | edgeHit;
  end

  assign statusVec = domR & ((~sensR & edgeLat) | (sensR & activeLvl) | softR) & PIN_VALID;
  assign irqOut    = |(statusVec & ~maskR);

  // read path
  always_comb begin
    case (strobe.rdBank)
      BANK_STATUS: rdVec = statusVec;
      BANK_MASK:   rdVec = maskR;
      BANK_SENS:   rdVec = sensR;
      BANK_SOFT:   rdVec = softR;
      BANK_POL:    rdVec = polR;
      BANK_DOM:    rdVec = domR;
      default:     rdVec = '0;
    endcase
    rdWord = '0;
    for (int w = 0; w < WORDS; w++)
      if (wordHit[w]) rdWord = rdVec[w*REG_BITS +: REG_BITS];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            busRdData <= '0;
    else if (strobe.rdEn) busRdData <= strobe.rdHit ? rdWord : '0;
  end

  // R3
  mask_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.maskSet |=> ((maskR & $past(wrBits)) == $past(wrBits)));
  // R3
  sens_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sensClr |=> ((sensR & $past(wrBits)) == '0));
  // R7
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ackWr && ((edgeHit & wrBits) == '0)) |=> ((edgeLat & $past(wrBits)) == '0));
  // R4
  dom_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (domR == '0 && edgeLat == '0) |=> (edgeLat == '0));
  // R8
  soft_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((statusVec & softR & domR) == (softR & domR & PIN_VALID)));
  // R9
  all_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (maskR == PIN_VALID) |-> !irqOut);

endmodule

// File: rtl/eic_top.sv
module eic_top
  import eic_pkg::*;
#(
  parameter int NUM_PINS = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWe,
  input  logic                busRe,
  input  logic [8:0]          busAddr,
  input  logic [31:0]         busWrData,
  output logic [31:0]         busRdData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic                irqOut
);

  localparam int WORDS = (NUM_PINS + REG_BITS - 1) / REG_BITS;
  localparam int PADW  = WORDS * REG_BITS;

  eic_strobe_t     strobe;
  logic [PADW-1:0] pinPad;
  logic [PADW-1:0] lvlNow;
  logic [PADW-1:0] lvlPrev;

  always_comb begin
    pinPad                 = '0;
    pinPad[NUM_PINS-1:0]   = pinIn;
  end

  eic_ctrl #(.WORDS(WORDS)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busWe   (busWe),
    .busRe   (busRe),
    .busAddr (busAddr),
    .strobe  (strobe)
  );

  eic_sync #(.WIDTH(PADW)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .rawIn   (pinPad),
    .lvlNow  (lvlNow),
    .lvlPrev (lvlPrev)
  );

  eic_datapath #(.NUM_PINS(NUM_PINS), .WORDS(WORDS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .busWrData (busWrData),
    .lvlNow    (lvlNow),
    .lvlPrev   (lvlPrev),
    .busRdData (busRdData),
    .irqOut    (irqOut)
  );

endmodule

// File: tb/tb_eic_top.sv
module tb_eic_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0;
  logic        busRe = 1'b0;
  logic [8:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [63:0] pinIn = '0;
  logic        irqOut;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eic_top #(.NUM_PINS(64)) dut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busRe(busRe), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .pinIn(pinIn), .irqOut(irqOut)
  );

  // word addresses (byte offset / 4)
  localparam logic [8:0] A_STATUS = 9'h000, A_ACK = 9'h010, A_MASK = 9'h020,
    A_MSET = 9'h030, A_MCLR = 9'h040, A_SENS = 9'h050, A_SSET = 9'h060,
    A_SCLR = 9'h070, A_SOFT = 9'h080, A_FSET = 9'h090, A_FCLR = 9'h0A0,
    A_POL = 9'h0C0, A_PSET = 9'h0D0, A_PCLR = 9'h0E0, A_DOM = 9'h100;

  // behavioural reference model
  logic [63:0] mMask, mSens, mSoft, mPol, mDom, mLat, mS1, mS2, mS3;
  logic [31:0] mRd;

  function automatic logic [63:0] mStatus();
    logic [63:0] st;
    for (int p = 0; p < 64; p++) begin
      logic lvl;
      lvl   = mPol[p] ? mS2[p] : !mS2[p];
      st[p] = mDom[p] && ((mSens[p] ? lvl : mLat[p]) || mSoft[p]);
    end
    return st;
  endfunction

  function automatic logic [31:0] mRead(input int bank, input int word);
    logic [63:0] v;
    if (word >= 2) return 32'h0;
    case (bank)
      0: v = mStatus();
      2: v = mMask;
      5: v = mSens;
      8: v = mSoft;
      12: v = mPol;
      16: v = mDom;
      default: v = '0;
    endcase
    return v[word*32 +: 32];
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mMask = '1; mSens = '0; mSoft = '0; mPol = '0; mDom = '0; mLat = '0;
      mS1 = '0; mS2 = '0; mS3 = '0; mRd = '0;
    end else begin
      int bank, word;
      logic [63:0] spread, newLat;
      bank = int'(busAddr[8:4]);
      word = int'(busAddr[3:0]);
      if (busRe) mRd = mRead(bank, word);
      spread = '0;
      if (busWe && word < 2) spread[word*32 +: 32] = busWrData;
      for (int p = 0; p < 64; p++) begin
        logic qual, ackIt;
        qual  = mPol[p] ? (mS2[p] && !mS3[p]) : (!mS2[p] && mS3[p]);
        ackIt = (bank == 1) && spread[p];
        newLat[p] = (mLat[p] && !ackIt) || (mDom[p] && !mSens[p] && qual);
      end
      mLat = newLat;
      case (bank)
        3: mMask = mMask | spread;
        4: mMask = mMask & ~spread;
        6: mSens = mSens | spread;
        7: mSens = mSens & ~spread;
        9: mSoft = mSoft | spread;
        10: mSoft = mSoft & ~spread;
        13: mPol = mPol | spread;
        14: mPol = mPol & ~spread;
        16: if (busWe && word < 2) mDom[word*32 +: 32] = busWrData;
        default: ;
      endcase
      mS3 = mS2; mS2 = mS1; mS1 = pinIn;
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // per-cycle comparison against the model (R2 read path, R9 request)
  always @(negedge clk) begin
    if (rstN && !done) begin
      check("R2 model read data", busRdData, mRd);
      check("R9 model request", {31'h0, irqOut}, {31'h0, |(mStatus() & ~mMask)});
    end
  end

  // caller is at a negedge for every task
  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    busWe = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    busRe = 1'b1; busAddr = a;
    @(negedge clk);
    busRe = 1'b0;
    d = busRdData;
  endtask

  task automatic rdChk(input string tag, input logic [8:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(tag, d, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state
    rdChk("R1 mask word0", A_MASK, 32'hFFFF_FFFF);
    rdChk("R1 mask word1", A_MASK + 9'd1, 32'hFFFF_FFFF);
    rdChk("R1 sens word0", A_SENS, 32'h0);
    rdChk("R1 dom word1", A_DOM + 9'd1, 32'h0);
    rdChk("R1 status word0", A_STATUS, 32'h0);
    check("R1 irq", {31'h0, irqOut}, 32'h0);

    // map and domain
    wr(A_DOM, 32'hFFFF_FFFF);
    wr(A_DOM + 9'd1, 32'hFFFF_FFFF);
    rdChk("R4 dom word1 direct write", A_DOM + 9'd1, 32'hFFFF_FFFF);
    rdChk("R2 ack alias reads zero", A_ACK, 32'h0);
    rdChk("R2 out-of-range word reads zero", A_MASK + 9'd5, 32'h0);

    // set/clear aliases
    wr(A_MCLR, 32'h0000_00F0);
    rdChk("R3 mask clear", A_MASK, 32'hFFFF_FF0F);
    wr(A_MCLR, 32'h0);
    rdChk("R3 clear with zero no effect", A_MASK, 32'hFFFF_FF0F);
    wr(A_MSET, 32'h0000_0010);
    rdChk("R3 mask set", A_MASK, 32'hFFFF_FF1F);

    // rising edge, pol 1, line 5
    wr(A_PSET, 32'h0000_0020);
    pinIn[5] = 1'b1;
    idle(3);
    rdChk("R5 rising edge latched", A_STATUS, 32'h0000_0020);
    check("R9 unmasked pending raises irq", {31'h0, irqOut}, 32'h1);
    pinIn[5] = 1'b0;
    idle(3);
    rdChk("R5 falling edge ignored for pol 1, latch held", A_STATUS, 32'h0000_0020);
    wr(A_ACK, 32'h0);
    rdChk("R7 ack zero no effect", A_STATUS, 32'h0000_0020);
    wr(A_ACK, 32'h0000_0020);
    rdChk("R7 ack clears latch", A_STATUS, 32'h0);

    // falling edge, pol 0, line 6
    pinIn[6] = 1'b1;
    idle(3);
    rdChk("R5 rising ignored for pol 0", A_STATUS, 32'h0);
    pinIn[6] = 1'b0;
    idle(3);
    rdChk("R5 falling edge latched for pol 0", A_STATUS, 32'h0000_0040);
    wr(A_ACK, 32'h0000_0040);

    // level mode, line 7 active high, with synchroniser latency
    wr(A_SSET, 32'h0000_0080);
    wr(A_PSET, 32'h0000_0080);
    rdChk("R6 inactive level no status", A_STATUS, 32'h0);
    pinIn[7] = 1'b1;
    rdChk("R10 not visible at edge k", A_STATUS, 32'h0);
    rdChk("R10 not visible at edge k+1", A_STATUS, 32'h0);
    rdChk("R10 visible at edge k+2", A_STATUS, 32'h0000_0080);
    pinIn[7] = 1'b0;
    idle(3);
    rdChk("R6 level drop clears status", A_STATUS, 32'h0);

    // soft trigger on masked line 4
    wr(A_FSET, 32'h0000_0010);
    rdChk("R8 soft word", A_SOFT, 32'h0000_0010);
    rdChk("R9 masked status visible", A_STATUS, 32'h0000_0010);
    check("R9 masked line no irq", {31'h0, irqOut}, 32'h0);
    wr(A_MCLR, 32'h0000_0010);
    check("R9 unmask raises irq", {31'h0, irqOut}, 32'h1);
    wr(A_FCLR, 32'h0000_0010);
    rdChk("R8 soft clear drops status", A_STATUS, 32'h0);
    check("R8 irq drops", {31'h0, irqOut}, 32'h0);

    // domain gating, line 32
    wr(A_DOM + 9'd1, 32'h0);
    wr(A_FSET + 9'd1, 32'h0000_0001);
    rdChk("R4 disabled domain hides soft", A_STATUS + 9'd1, 32'h0);
    rdChk("R4 soft still stored", A_SOFT + 9'd1, 32'h0000_0001);
    wr(A_DOM + 9'd1, 32'hFFFF_FFFF);
    rdChk("R4 enabled domain shows soft", A_STATUS + 9'd1, 32'h0000_0001);
    wr(A_FCLR + 9'd1, 32'h0000_0001);

    // line 63 edge in second word
    wr(A_PSET + 9'd1, 32'h8000_0000);
    pinIn[63] = 1'b1;
    idle(3);
    rdChk("R2 line 63 at word1 bit31", A_STATUS + 9'd1, 32'h8000_0000);
    wr(A_ACK + 9'd1, 32'h8000_0000);
    rdChk("R7 ack word1", A_STATUS + 9'd1, 32'h0);
    pinIn[63] = 1'b0;
    idle(3);

    // random mix against the model
    for (int i = 0; i < 4000; i++) begin
      int sel;
      logic [4:0] banks [15];
      banks = '{5'd0, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd6, 5'd7, 5'd8,
                5'd9, 5'd10, 5'd12, 5'd13, 5'd14, 5'd16};
      if (($urandom % 4) == 0) pinIn[$urandom % 64] = ~pinIn[$urandom % 64];
      if (($urandom % 3) == 0) pinIn ^= (64'h1 << ($urandom % 64));
      sel       = $urandom % 15;
      busAddr   = {banks[sel], 4'($urandom % 3)};
      busWrData = $urandom & $urandom;
      busWe     = (($urandom % 3) == 0);
      busRe     = (($urandom % 2) == 0);
      @(negedge clk);
    end
    busWe = 1'b0;
    busRe = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule